// File: doc/BRIEF.md
# Dual-Base Modular Exponentiation Sequencer

This block drives an external modular multiplier to produce g0^e0 · g1^e1 mod m in a single most-significant-first sweep over both exponents. It also has a single-base mode (g0^e0) and a one-shot product mode (g0 · g1). Software places the two bases, the two exponents, the Montgomery form of 1, an exponent length and a mode on the inputs and pulses `start`. The sequencer then issues a series of square and multiply operations to the multiplier and pulses `done` when `result` is valid.

A four-entry operand table holds {1, g0, g1, g0·g1}. In dual-base mode the cross product g0·g1 is formed by the first multiplier operation, before the sweep begins. At every bit position the accumulator is squared. It is then multiplied by the table entry that the pair of exponent bits at that position selects. The multiply is left out when that pair is zero, unless the constant-time option is set. The number of multiplier operations issued by the run is reported on `mul_count`. Exponents are unsigned. Domain conversion and modular inverses are left to software.

Top module: `dbexp_ctrl`

## Requirements
- R1: With `mode`=0 (product), `result` equals the multiplier's output for operands `base0`,`base1`, `exp_len` has no effect, and `mul_count` is 1.
- R2: With `mode`=1 (single base; code 3 behaves the same), `result` = base0^E0 and `mul_count` = L + (number of ones in E0). Here L = `exp_len` and E0 = the low L bits of `exp0`.
- R3: With `mode`=2 (dual base), `result` = base0^E0 · base1^E1 and `mul_count` = 1 + L + (number of positions i < L where exp0[i] or exp1[i] is 1).
- R4: Exponent bits at positions L and above have no effect on `result` or `mul_count`, so a shorter exponent acts as if padded with leading zeros.
- R5: In an exponentiation mode with L = 0, `done` pulses in the cycle after `start`, `result` equals `one_mont`, and no multiplier operation is issued (`mul_count` = 0).
- R6: With `const_time`=1, every bit position issues a square and a multiply. `mul_count` is then 2·L in single mode and 2·L+1 in dual mode, whatever the exponent values, and `result` is unchanged.
- R7: `mul_start` is a one-cycle pulse, issued only while `busy` is high. No new operation is issued before the previous one's `mul_done`.
- R8: A `start` pulse while `busy` is high is ignored: it produces no extra result, and the run in progress completes with its original operands. `result` stays stable while `busy` is high, except in the cycle where `done` rises.
- R9: A `start` given in the same cycle that `done` pulses is accepted as a new run.
- R10: After reset, `busy`, `done`, `mul_start`, `result` and `mul_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (taken only while idle) |
| mode | input | 2 | 0 product, 1 single base, 2 dual base |
| const_time | input | 1 | Multiply at every bit position |
| exp_len | input | LEN_W | Number of exponent bits to process |
| base0 | input | N_BITS | First base (Montgomery form) |
| base1 | input | N_BITS | Second base (Montgomery form) |
| exp0 | input | E_BITS | Exponent for base0 |
| exp1 | input | E_BITS | Exponent for base1 |
| one_mont | input | N_BITS | Montgomery form of 1 |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse: result valid |
| result | output | N_BITS | Final value |
| mul_count | output | CNT_W | Multiplier operations issued by the last run |
| mul_start | output | 1 | Issue one multiplier operation |
| mul_a | output | N_BITS | Multiplier operand A |
| mul_b | output | N_BITS | Multiplier operand B |
| mul_done | input | 1 | Multiplier operation finished |
| mul_res | input | N_BITS | Multiplier output |

## Verification
The end of one run and the acceptance of the next can fall in the same cycle: `done` pulses while `busy` is already low, and a `start` presented then must open a fresh run. The scoreboard driver raises the next `start` at the first idle sample, which is the `done` cycle, so this coincidence occurs on almost every back-to-back run. It is counted, and the later run's result and operation count must still match the model. A second overlap is a `start` arriving mid-run. It is injected with different operands, and it is judged by the absence of any extra result and by the correctness of the run in progress.

// File: rtl/dbexp_pkg.sv
// Shared types for the dual-base exponentiation sequencer.
package dbexp_pkg;
    typedef enum logic [1:0] {
        MODE_PROD   = 2'd0,
        MODE_SINGLE = 2'd1,
        MODE_DUAL   = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } state_e;

    typedef enum logic [1:0] {
        OP_PROD = 2'd0,   // one-shot base0*base1
        OP_PRE  = 2'd1,   // cross product for the table
        OP_SQR  = 2'd2,   // acc*acc
        OP_MUL  = 2'd3    // acc*table[sel]
    } op_e;
endpackage

// File: rtl/dbexp_optab.sv
// Operand table: entry 0 = Montgomery one, entry 2^j = base j, last entry =
// product of all bases (written once by the sequencer). Assumes NB = 2 for
// the cross-product slot; other composite slots load as zero.
module dbexp_optab #(
    parameter int N_BITS = 32,
    parameter int NB     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [N_BITS-1:0]          one_val,
    input  logic [NB-1:0][N_BITS-1:0]  bases,
    input  logic                       pair_we,
    input  logic [N_BITS-1:0]          pair_val,
    input  logic [NB-1:0]              sel_a,
    input  logic [NB-1:0]              sel_b,
    output logic [N_BITS-1:0]          val_a,
    output logic [N_BITS-1:0]          val_b
);
    localparam int DEPTH = 1 << NB;

    logic [DEPTH-1:0][N_BITS-1:0] ent;

    for (genvar k = 0; k < DEPTH; k++) begin : g_ent
        logic [N_BITS-1:0] val;
        if (k == 0) begin : g_one
            // Entry 0 holds the accumulator's start value.
            always_ff @(posedge clk) begin
                if (!rst_n)    val <= '0;
                else if (load) val <= one_val;
            end
        end else if ((k & (k - 1)) == 0) begin : g_base
            // Single-base entry loaded at the start of a run.
            always_ff @(posedge clk) begin
                if (!rst_n)    val <= '0;
                else if (load) val <= bases[$clog2(k)];
            end
        end else begin : g_prod
            // Composite entry: cleared at load, filled by the precompute step.
            always_ff @(posedge clk) begin
                if (!rst_n)                           val <= '0;
                else if (load)                        val <= '0;
                else if (pair_we && k == DEPTH - 1)   val <= pair_val;
            end
        end
        assign ent[k] = val;
    end

    assign val_a = ent[sel_a];
    assign val_b = ent[sel_b];
endmodule

// File: rtl/dbexp_scan.sv
// Exponent scanner: latches both exponents, walks a bit position from
// length-1 down to 0 and presents the table index {e1[i], e0[i]}.
// Assumes the caller never loads a zero length (handled upstream).
module dbexp_scan #(
    parameter int E_BITS = 16,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              dual,
    input  logic [LEN_W-1:0]  len,
    input  logic [E_BITS-1:0] e0,
    input  logic [E_BITS-1:0] e1,
    input  logic              step,
    output logic [1:0]        sel,
    output logic              last
);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(E_BITS);

    logic [E_BITS-1:0] e0_q, e1_q;
    logic [LEN_W-1:0]  pos;
    logic              dual_q;

    // Latch exponents and set or move the scan position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e0_q   <= '0;
            e1_q   <= '0;
            pos    <= '0;
            dual_q <= 1'b0;
        end else if (load) begin
            e0_q   <= e0;
            e1_q   <= e1;
            dual_q <= dual;
            pos    <= (len > MAX_LEN) ? (MAX_LEN - 1'b1) : (len - 1'b1);
        end else if (step) begin
            pos <= pos - 1'b1;
        end
    end

    assign sel  = {dual_q & e1_q[pos], e0_q[pos]};
    assign last = (pos == '0);
endmodule

// File: rtl/dbexp_fsm.sv
// Sequencer: decides which multiplier operation to issue, owns the
// accumulator, the result, the operation counter and the done pulse.
// Assumes the multiplier answers each mul_start with exactly one mul_done.
module dbexp_fsm
    import dbexp_pkg::*;
#(
    parameter int N_BITS = 32,
    parameter int LEN_W  = 5,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic              const_time,
    input  logic [LEN_W-1:0]  exp_len,
    input  logic [N_BITS-1:0] one_mont,
    input  logic [1:0]        sel,
    input  logic              last,
    input  logic [N_BITS-1:0] tab_a,
    input  logic [N_BITS-1:0] tab_b,
    input  logic              mul_done,
    input  logic [N_BITS-1:0] mul_res,
    output logic              accept,
    output logic              dual_sel,
    output logic              step,
    output logic              pair_we,
    output logic [1:0]        tab_sel_b,
    output logic              busy,
    output logic              done,
    output logic [N_BITS-1:0] result,
    output logic [CNT_W-1:0]  mul_count,
    output logic              mul_start,
    output logic [N_BITS-1:0] mul_a,
    output logic [N_BITS-1:0] mul_b
);
    state_e            state;
    op_e               op;
    logic [N_BITS-1:0] acc;
    logic              ct_q;
    logic              want_mul;
    logic              fin;

    assign accept   = start && (state == ST_IDLE);
    assign dual_sel = (mode == MODE_DUAL);
    assign want_mul = ct_q || (sel != 2'b00);
    // Last operation of a bit position has returned on the final position.
    assign fin = (state == ST_WAIT) && mul_done && last &&
                 ((op == OP_MUL) || (op == OP_SQR && !want_mul));
    assign step = (state == ST_WAIT) && mul_done && !last &&
                  ((op == OP_MUL) || (op == OP_SQR && !want_mul));
    assign pair_we   = (state == ST_WAIT) && mul_done && (op == OP_PRE);
    assign tab_sel_b = (op == OP_MUL) ? sel : 2'd2;
    assign busy      = (state != ST_IDLE);
    assign mul_start = (state == ST_ISSUE);

    // Operand routing for the operation being issued.
    always_comb begin
        unique case (op)
            OP_PROD, OP_PRE: begin mul_a = tab_a; mul_b = tab_b; end
            OP_SQR:          begin mul_a = acc;   mul_b = acc;   end
            default:         begin mul_a = acc;   mul_b = tab_b; end
        endcase
    end

    // Main sequencing: state, operation, accumulator, result and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            op        <= OP_SQR;
            acc       <= '0;
            ct_q      <= 1'b0;
            done      <= 1'b0;
            result    <= '0;
            mul_count <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        ct_q      <= const_time;
                        acc       <= one_mont;
                        mul_count <= '0;
                        if (mode == MODE_PROD) begin
                            op    <= OP_PROD;
                            state <= ST_ISSUE;
                        end else if (exp_len == '0) begin
                            result <= one_mont;
                            done   <= 1'b1;
                        end else if (mode == MODE_DUAL) begin
                            op    <= OP_PRE;
                            state <= ST_ISSUE;
                        end else begin
                            op    <= OP_SQR;
                            state <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    mul_count <= mul_count + 1'b1;
                    state     <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mul_done) begin
                        unique case (op)
                            OP_PROD: begin
                                result <= mul_res;
                                done   <= 1'b1;
                                state  <= ST_IDLE;
                            end
                            OP_PRE: begin
                                op    <= OP_SQR;
                                state <= ST_ISSUE;
                            end
                            OP_SQR: begin
                                acc <= mul_res;
                                if (want_mul) begin
                                    op    <= OP_MUL;
                                    state <= ST_ISSUE;
                                end else if (fin) begin
                                    result <= mul_res;
                                    done   <= 1'b1;
                                    state  <= ST_IDLE;
                                end else begin
                                    state <= ST_ISSUE;
                                end
                            end
                            default: begin
                                acc <= mul_res;
                                op  <= OP_SQR;
                                if (fin) begin
                                    result <= mul_res;
                                    done   <= 1'b1;
                                    state  <= ST_IDLE;
                                end else begin
                                    state <= ST_ISSUE;
                                end
                            end
                        endcase
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dbexp_ctrl.sv
// Top of the dual-base exponentiation sequencer. Wires the operand table,
// the exponent scanner and the sequencer; the multiplier sits outside.
// Assumes all operands are already in the multiplier's Montgomery domain.
module dbexp_ctrl
    import dbexp_pkg::*;
#(
    parameter int N_BITS = 32,
    parameter int E_BITS = 16,
    parameter int LEN_W  = $clog2(E_BITS + 1),
    parameter int CNT_W  = $clog2(2 * E_BITS + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic              const_time,
    input  logic [LEN_W-1:0]  exp_len,
    input  logic [N_BITS-1:0] base0,
    input  logic [N_BITS-1:0] base1,
    input  logic [E_BITS-1:0] exp0,
    input  logic [E_BITS-1:0] exp1,
    input  logic [N_BITS-1:0] one_mont,
    output logic              busy,
    output logic              done,
    output logic [N_BITS-1:0] result,
    output logic [CNT_W-1:0]  mul_count,
    output logic              mul_start,
    output logic [N_BITS-1:0] mul_a,
    output logic [N_BITS-1:0] mul_b,
    input  logic              mul_done,
    input  logic [N_BITS-1:0] mul_res
);
    localparam int NB = 2;

    logic              accept, dual_sel, step, pair_we, last;
    logic [1:0]        sel, tab_sel_b;
    logic [N_BITS-1:0] tab_a, tab_b;

    dbexp_optab #(.N_BITS(N_BITS), .NB(NB)) u_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .one_val  (one_mont),
        .bases    ({base1, base0}),
        .pair_we  (pair_we),
        .pair_val (mul_res),
        .sel_a    (2'd1),
        .sel_b    (tab_sel_b),
        .val_a    (tab_a),
        .val_b    (tab_b)
    );

    dbexp_scan #(.E_BITS(E_BITS), .LEN_W(LEN_W)) u_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .dual  (dual_sel),
        .len   (exp_len),
        .e0    (exp0),
        .e1    (exp1),
        .step  (step),
        .sel   (sel),
        .last  (last)
    );

    dbexp_fsm #(.N_BITS(N_BITS), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode       (mode),
        .const_time (const_time),
        .exp_len    (exp_len),
        .one_mont   (one_mont),
        .sel        (sel),
        .last       (last),
        .tab_a      (tab_a),
        .tab_b      (tab_b),
        .mul_done   (mul_done),
        .mul_res    (mul_res),
        .accept     (accept),
        .dual_sel   (dual_sel),
        .step       (step),
        .pair_we    (pair_we),
        .tab_sel_b  (tab_sel_b),
        .busy       (busy),
        .done       (done),
        .result     (result),
        .mul_count  (mul_count),
        .mul_start  (mul_start),
        .mul_a      (mul_a),
        .mul_b      (mul_b)
    );
endmodule

// File: rtl/dbexp_chk.sv
// Protocol checker for dbexp_ctrl, attached by bind. Observes ports only.
module dbexp_chk #(
    parameter int N_BITS = 32,
    parameter int LEN_W  = 5,
    parameter int CNT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        mode,
    input logic [LEN_W-1:0]  exp_len,
    input logic [N_BITS-1:0] one_mont,
    input logic              busy,
    input logic              done,
    input logic [N_BITS-1:0] result,
    input logic [CNT_W-1:0]  mul_count,
    input logic              mul_start,
    input logic              mul_done
);
    logic [LEN_W-1:0] len_q;
    logic             exp_run_q;
    logic             outstanding;

    // Remember the length and kind of the run last accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q     <= '0;
            exp_run_q <= 1'b0;
        end else if (start && !busy) begin
            len_q     <= exp_len;
            exp_run_q <= (mode != 2'd0);
        end
    end

    // Track an operation issued but not yet answered.
    always_ff @(posedge clk) begin
        if (!rst_n)         outstanding <= 1'b0;
        else if (mul_start) outstanding <= 1'b1;
        else if (mul_done)  outstanding <= 1'b0;
    end

    a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mul_start |=> !mul_start);
    a_r7_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        mul_start |-> busy);
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        mul_start |-> !outstanding);
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (done || $stable(result)));
    a_r5_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode != 2'd0 && exp_len == '0)
        |=> (done && result == $past(one_mont) && mul_count == '0));
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (done && exp_run_q) |-> (int'(mul_count) <= 2 * int'(len_q) + 1));
endmodule

bind dbexp_ctrl dbexp_chk #(.N_BITS(N_BITS), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .exp_len   (exp_len),
    .one_mont  (one_mont),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .mul_count (mul_count),
    .mul_start (mul_start),
    .mul_done  (mul_done)
);

// File: tb/dbexp_ctrl_bench.sv
// Scoreboard bench: a driver pushes expected results, a monitor checks them.
module dbexp_ctrl_bench;
    localparam int N  = 24;
    localparam int E  = 12;
    localparam int LW = $clog2(E + 1);
    localparam int CW = $clog2(2 * E + 2);
    localparam longint unsigned MODV = 64'd16777199;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic          const_time = 1'b0;
    logic [LW-1:0] exp_len = '0;
    logic [N-1:0]  base0 = '0, base1 = '0, one_mont = 24'd1;
    logic [E-1:0]  exp0 = '0, exp1 = '0;
    logic          busy, done, mul_start, mul_done;
    logic [N-1:0]  result, mul_a, mul_b, mul_res;
    logic [CW-1:0] mul_count;

    int checks = 0, fails = 0, b2b_hits = 0, overlap_errs = 0;
    bit finished = 1'b0;
    logic [N-1:0] q_res[$];
    int           q_cnt[$];
    string        q_tag[$];

    always #5 clk = ~clk;

    dbexp_ctrl #(.N_BITS(N), .E_BITS(E)) u_dbexp_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .const_time(const_time), .exp_len(exp_len), .base0(base0),
        .base1(base1), .exp0(exp0), .exp1(exp1), .one_mont(one_mont),
        .busy(busy), .done(done), .result(result), .mul_count(mul_count),
        .mul_start(mul_start), .mul_a(mul_a), .mul_b(mul_b),
        .mul_done(mul_done), .mul_res(mul_res)
    );

    function automatic logic [N-1:0] mm(input logic [N-1:0] a, input logic [N-1:0] b);
        longint unsigned p;
        p = (longint'(a) * longint'(b)) % MODV;
        return N'(p);
    endfunction

    // Behavioural multiplier: plain a*b mod m after three cycles.
    logic [2:0]   m_lat;
    logic         m_busy;
    logic [N-1:0] m_a, m_b;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lat <= '0; m_busy <= 1'b0; mul_done <= 1'b0; mul_res <= '0;
            m_a <= '0; m_b <= '0;
        end else begin
            mul_done <= 1'b0;
            if (mul_start) begin
                if (m_busy) overlap_errs <= overlap_errs + 1;
                m_a <= mul_a; m_b <= mul_b; m_lat <= 3'd3; m_busy <= 1'b1;
            end else if (m_busy) begin
                if (m_lat == 3'd1) begin
                    mul_done <= 1'b1;
                    mul_res  <= mm(m_a, m_b);
                    m_busy   <= 1'b0;
                end
                m_lat <= m_lat - 3'd1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: compute the expected outcome, queue it, then launch the run.
    task automatic launch(input logic [1:0] md, input bit ct, input logic [N-1:0] g0,
                          input logic [N-1:0] g1, input logic [E-1:0] x0,
                          input logic [E-1:0] x1, input int len, input string tag);
        logic [N-1:0] r;
        int cnt;
        bit dual;
        dual = (md == 2'd2);
        if (md == 2'd0) begin
            r = mm(g0, g1); cnt = 1;
        end else begin
            r = one_mont; cnt = dual ? 1 : 0;
            if (len == 0) cnt = 0;
            for (int i = len - 1; i >= 0; i--) begin
                r = mm(r, r); cnt++;
                if (ct || x0[i] || (dual && x1[i])) cnt++;
                if (x0[i]) r = mm(r, g0);
                if (dual && x1[i]) r = mm(r, g1);
            end
        end
        q_res.push_back(r); q_cnt.push_back(cnt); q_tag.push_back(tag);
        while (busy) @(negedge clk);
        if (done) b2b_hits++;
        mode = md; const_time = ct; base0 = g0; base1 = g1;
        exp0 = x0; exp1 = x1; exp_len = LW'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        base0 = '0; base1 = '0; exp0 = '0; exp1 = '0;
    endtask

    // Monitor: compare each completed run against the queue.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q_res.size() == 0) begin
                chk(1'b0, "R8 unexpected result", longint'(result), 0);
            end else begin
                logic [N-1:0] er;
                int ec;
                string tg;
                er = q_res.pop_front(); ec = q_cnt.pop_front(); tg = q_tag.pop_front();
                chk(result == er, {tg, " result"}, longint'(result), longint'(er));
                chk(int'(mul_count) == ec, {tg, " mul_count"}, longint'(mul_count), longint'(ec));
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R10 busy", longint'(busy), 0);
        chk(done == 1'b0, "R10 done", longint'(done), 0);
        chk(mul_start == 1'b0, "R10 mul_start", longint'(mul_start), 0);
        chk(result == '0, "R10 result", longint'(result), 0);
        chk(mul_count == '0, "R10 mul_count", longint'(mul_count), 0);
        rst_n = 1'b1;
        @(negedge clk);

        launch(2'd0, 0, 24'd12345, 24'd67890, 12'hABC, 12'h123, 9, "R1 product");
        launch(2'd1, 0, 24'd7, 24'd0, 12'hB6D, 12'h000, 12, "R2 single full");
        launch(2'd3, 0, 24'd31337, 24'd0, 12'h0F1, 12'h000, 12, "R2 mode3 single");
        launch(2'd1, 0, 24'd99991, 24'd0, 12'hFF3, 12'hFFF, 5, "R4 single padded");
        launch(2'd2, 0, 24'd4242, 24'd777, 12'hA5C, 12'h3F0, 12, "R3 dual full");
        launch(2'd2, 0, 24'd123, 24'd4567, 12'hF91, 12'hE24, 7, "R4 dual padded");
        launch(2'd2, 0, 24'd55, 24'd66, 12'h000, 12'h000, 8, "R3 dual zero exps");
        launch(2'd1, 0, 24'd555, 24'd0, 12'hFFF, 12'h000, 0, "R5 single len0");
        launch(2'd2, 0, 24'd555, 24'd9, 12'hFFF, 12'hFFF, 0, "R5 dual len0");
        launch(2'd1, 1, 24'd1001, 24'd0, 12'h000, 12'h000, 10, "R6 ct single zero");
        launch(2'd1, 1, 24'd1001, 24'd0, 12'h3A5, 12'h000, 10, "R6 ct single");
        launch(2'd2, 1, 24'd88, 24'd999, 12'h123, 12'h800, 12, "R6 ct dual");

        // R8: a start pulse mid-run must be ignored.
        launch(2'd2, 0, 24'd313, 24'd171, 12'h5A5, 12'h0FF, 12, "R8 run under poke");
        repeat (6) @(negedge clk);
        chk(busy == 1'b1, "R8 busy before poke", longint'(busy), 1);
        mode = 2'd0; base0 = 24'd3; base1 = 24'd5; exp_len = LW'(1); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        launch(2'd1, 0, 24'd2, 24'd0, 12'h00A, 12'h000, 4, "R9 back to back");

        while (busy || q_res.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(q_res.size() == 0, "R8 scoreboard drained", longint'(q_res.size()), 0);
        chk(overlap_errs == 0, "R7 overlapping issue", longint'(overlap_errs), 0);
        chk(b2b_hits > 0, "R9 start in done cycle", longint'(b2b_hits), 1);
        summary();
    end
endmodule